// File: doc/BRIEF.md
# Parallel Quadrature Mixer with CORDIC Oscillator

This block is the mixing stage at the front of a wideband digital down-converter. The converter delivers samples faster than the logic clock can run, so each clock carries a word of four real samples. One shared 32-bit phase accumulator steps four samples' worth of phase per beat. Each lane adds its own multiple of the tuning word, so the four lanes see consecutive sample phases.

The top 16 bits of each lane phase go to a pipelined CORDIC rotator. The rotator first folds the angle into the right half-plane and then makes cosine and negated sine. There is no stored waveform table. Each real sample is multiplied by both values to give an I and a Q output for that lane. These outputs go on to a decimating filter chain.

The tuning word is an input and may change on any beat. A tuning word of 0x55555555 is one third of a cycle per sample, which brings a 400 MHz carrier sampled at 1.2 GSPS down to baseband.

Top module: `par_nco_mixer`

## Requirements
- R1: While reset is asserted, and on every cycle where valid_o is low, valid_o, i_o and q_o are all zero.
- R2: Each beat accepted with valid_i high gives exactly one valid_o beat, ITER+2 clocks later (16 by default). Beats come out in the order they went in.
- R3: The phase of lane k (k = 0..3, sample bits [14k+13:14k]) is p_k = bits [31:16] of (acc + k*tune_i), where acc is the accumulator value before the beat.
- R4: The accumulator is zero after reset. It adds 4*tune_i (mod 2^32) on each beat with valid_i high and holds on cycles where valid_i is low.
- R5: For a lane with signed sample x and angle phi = 2*pi*p_k/65536, the output at i_o[16k+15:16k] is round(x*cos(phi)) and the output at q_o[16k+15:16k] is round(-x*sin(phi)). Both are 16-bit signed and within +/-2 LSB.
- R6: R5 holds in all four quadrants of phi, including angles exactly on a quarter turn.
- R7: A new tuning word is used from the beat on which it is presented, for all four lanes alike. The phase already accumulated carries on without a jump.
- R8: With a tuning word of zero, all four lanes share one phase, and that phase stays fixed from beat to beat.
- R9: Full-scale samples (-8192 and 8191) produce outputs within R5's tolerance, with no wrap-around.
- R10: A tuning word of 0x55555555 steps the lane phases by one third of a cycle per sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fabric clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample word present this cycle |
| tune_i | input | 32 | Phase increment per sample |
| samples_i | input | 56 | Four 14-bit signed samples, lane 0 in the low bits |
| valid_o | output | 1 | Mixed word present this cycle |
| i_o | output | 64 | Four 16-bit signed in-phase results |
| q_o | output | 64 | Four 16-bit signed quadrature results |

## Verification
The bench drives pseudo-random samples at the one-third-cycle tuning word. This shows the lane offsets and the accumulator stepping against a cosine and sine reference computed in the bench. A quarter-turn tuning word puts the four lanes exactly on the axes, where any error in the quadrant fold shows up as a sign error. Beats separated by idle gaps show whether the accumulator advances only on accepted beats. A tuning word that changes on every beat, followed by a zero word, shows whether a new tuning word is applied to all lanes in the same cycle and whether the accumulated phase continues without a jump. Full-scale samples at both extremes expose any rounding or width wrap in the multiplier.

// File: rtl/mix_pkg.sv
package mix_pkg;
  // Angle width inside the rotator; a full turn is 2**ANG_W.
  localparam int ANG_W   = 20;
  // Fractional bits of the unit-amplitude cosine and sine.
  localparam int CS_FRAC = 15;

  // atan(2**-idx), scaled to 2**ANG_W per turn.
  function automatic int atan_tab(input int idx);
    case (idx)
      0:  return 131072;
      1:  return 77376;
      2:  return 40884;
      3:  return 20753;
      4:  return 10417;
      5:  return 5213;
      6:  return 2607;
      7:  return 1304;
      8:  return 652;
      9:  return 326;
      10: return 163;
      11: return 81;
      12: return 41;
      13: return 20;
      default: return 166886 >>> idx;
    endcase
  endfunction
endpackage

// File: rtl/nco_phase_gen.sv
module nco_phase_gen #(
  parameter int LANES = 4,
  parameter int ACC_W = 32,
  parameter int PH_W  = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [ACC_W-1:0]        tune_i,
  output logic                    valid_o,
  output logic [LANES*PH_W-1:0]   phase_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] step;

  assign step = ACC_W'(LANES) * tune_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) acc_q <= acc_q + step;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [ACC_W-1:0] lane_ph;
    logic [PH_W-1:0]  ph_q;
    assign lane_ph = acc_q + ACC_W'(k) * tune_i;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ph_q <= '0;
      else         ph_q <= lane_ph[ACC_W-1 -: PH_W];
    end
    assign phase_o[k*PH_W +: PH_W] = ph_q;
  end

  p_acc_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> acc_q == $past(acc_q));
  p_acc_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> acc_q == $past(acc_q) + ACC_W'(LANES) * $past(tune_i));
endmodule

// File: rtl/cordic_sincos.sv
module cordic_sincos
  import mix_pkg::*;
#(
  parameter int PH_W = 16,
  parameter int XY_W = 20,
  parameter int ITER = 14,
  parameter int CS_W = 18
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic [PH_W-1:0]        phase_i,
  output logic                   valid_o,
  output logic signed [CS_W-1:0] cos_o,
  output logic signed [CS_W-1:0] nsin_o
);
  localparam int SH = XY_W - 3 - CS_FRAC;
  // Start vector pre-scaled by the inverse rotator gain.
  localparam logic signed [XY_W-1:0] X_INIT =
    XY_W'($rtoi(0.6072529350 * (2.0 ** (XY_W - 3)) + 0.5));

  // Fold into [-pi/2, pi/2): quadrants 1 and 2 are rotated by pi and negated.
  logic                    neg0;
  logic [PH_W-1:0]         fold;
  logic signed [ANG_W-1:0] z0;
  assign neg0 = phase_i[PH_W-1] ^ phase_i[PH_W-2];
  assign fold = {phase_i[PH_W-1] ^ neg0, phase_i[PH_W-2:0]};
  assign z0   = $signed({fold, {(ANG_W-PH_W){1'b0}}});

  logic signed [XY_W-1:0]  x_q [ITER];
  logic signed [XY_W-1:0]  y_q [ITER];
  logic signed [ANG_W-1:0] z_q [ITER];
  logic                    neg_q [ITER];
  logic                    vld_q [ITER];

  for (genvar i = 0; i < ITER; i++) begin : g_stage
    localparam logic signed [ANG_W-1:0] ATAN = ANG_W'(atan_tab(i));
    logic signed [XY_W-1:0]  xi, yi;
    logic signed [ANG_W-1:0] zi;
    logic                    ni, vi;
    if (i == 0) begin : g_first
      assign xi = X_INIT;
      assign yi = '0;
      assign zi = z0;
      assign ni = neg0;
      assign vi = valid_i;
    end else begin : g_next
      assign xi = x_q[i-1];
      assign yi = y_q[i-1];
      assign zi = z_q[i-1];
      assign ni = neg_q[i-1];
      assign vi = vld_q[i-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        x_q[i]   <= '0;
        y_q[i]   <= '0;
        z_q[i]   <= '0;
        neg_q[i] <= 1'b0;
        vld_q[i] <= 1'b0;
      end else begin
        if (zi[ANG_W-1]) begin
          x_q[i] <= xi + (yi >>> i);
          y_q[i] <= yi - (xi >>> i);
          z_q[i] <= zi + ATAN;
        end else begin
          x_q[i] <= xi - (yi >>> i);
          y_q[i] <= yi + (xi >>> i);
          z_q[i] <= zi - ATAN;
        end
        neg_q[i] <= ni;
        vld_q[i] <= vi;
      end
    end
  end

  logic signed [XY_W-1:0] x_sh, y_sh;
  logic signed [CS_W-1:0] cos_t, sin_t;
  assign x_sh   = x_q[ITER-1] >>> SH;
  assign y_sh   = y_q[ITER-1] >>> SH;
  assign cos_t  = CS_W'(x_sh);
  assign sin_t  = CS_W'(y_sh);
  assign cos_o  = neg_q[ITER-1] ? -cos_t : cos_t;
  assign nsin_o = neg_q[ITER-1] ? sin_t : -sin_t;
  assign valid_o = vld_q[ITER-1];

  // Residual angle must be within the last step plus table rounding.
  localparam logic [ANG_W-1:0] Z_TOL = ANG_W'(atan_tab(ITER-1) + ITER);
  localparam logic signed [CS_W-1:0] MAG_LIM = CS_W'((2 ** CS_FRAC) + 16);
  logic [ANG_W-1:0] z_abs;
  assign z_abs = z_q[ITER-1][ANG_W-1] ? ANG_W'(-z_q[ITER-1]) : ANG_W'(z_q[ITER-1]);

  p_converge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q[ITER-1] |-> z_abs <= Z_TOL);
  p_unit_mag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (cos_o <= MAG_LIM && cos_o >= -MAG_LIM &&
                 nsin_o <= MAG_LIM && nsin_o >= -MAG_LIM));
endmodule

// File: rtl/mix_lane.sv
module mix_lane
  import mix_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int CS_W   = 18,
  parameter int OUT_W  = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] sample_i,
  input  logic signed [CS_W-1:0]   cos_i,
  input  logic signed [CS_W-1:0]   nsin_i,
  output logic signed [OUT_W-1:0]  i_o,
  output logic signed [OUT_W-1:0]  q_o
);
  localparam int PW = DATA_W + CS_W;
  localparam logic signed [PW-1:0] RND = PW'(1) <<< (CS_FRAC - 1);

  logic signed [PW-1:0] prod_i, prod_q, rnd_i, rnd_q;
  assign prod_i = sample_i * cos_i;
  assign prod_q = sample_i * nsin_i;
  assign rnd_i  = (prod_i + RND) >>> CS_FRAC;
  assign rnd_q  = (prod_q + RND) >>> CS_FRAC;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      i_o <= '0;
      q_o <= '0;
    end else begin
      i_o <= valid_i ? rnd_i[OUT_W-1:0] : '0;
      q_o <= valid_i ? rnd_q[OUT_W-1:0] : '0;
    end
  end

  // Dropped high bits must be pure sign extension.
  p_no_clip_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ((rnd_i[PW-1:OUT_W-1] == '0 || rnd_i[PW-1:OUT_W-1] == '1) &&
                 (rnd_q[PW-1:OUT_W-1] == '0 || rnd_q[PW-1:OUT_W-1] == '1)));
endmodule

// File: rtl/par_nco_mixer.sv
module par_nco_mixer #(
  parameter int LANES  = 4,
  parameter int DATA_W = 14,
  parameter int ACC_W  = 32,
  parameter int PH_W   = 16,
  parameter int ITER   = 14,
  parameter int XY_W   = 20,
  parameter int CS_W   = 18,
  parameter int OUT_W  = DATA_W + 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      valid_i,
  input  logic [ACC_W-1:0]          tune_i,
  input  logic [LANES*DATA_W-1:0]   samples_i,
  output logic                      valid_o,
  output logic [LANES*OUT_W-1:0]    i_o,
  output logic [LANES*OUT_W-1:0]    q_o
);
  localparam int SDLY = ITER + 1;

  logic                  ph_vld;
  logic [LANES*PH_W-1:0] ph;
  logic [LANES-1:0]      lane_vld;
  logic [LANES*DATA_W-1:0] samp_d [SDLY];

  nco_phase_gen #(.LANES(LANES), .ACC_W(ACC_W), .PH_W(PH_W)) u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .tune_i  (tune_i),
    .valid_o (ph_vld),
    .phase_o (ph)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < SDLY; j++) samp_d[j] <= '0;
    end else begin
      samp_d[0] <= samples_i;
      for (int j = 1; j < SDLY; j++) samp_d[j] <= samp_d[j-1];
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic signed [CS_W-1:0] cos_w, nsin_w;
    cordic_sincos #(.PH_W(PH_W), .XY_W(XY_W), .ITER(ITER), .CS_W(CS_W)) u_cordic (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (ph_vld),
      .phase_i (ph[k*PH_W +: PH_W]),
      .valid_o (lane_vld[k]),
      .cos_o   (cos_w),
      .nsin_o  (nsin_w)
    );
    mix_lane #(.DATA_W(DATA_W), .CS_W(CS_W), .OUT_W(OUT_W)) u_mix (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .valid_i  (lane_vld[k]),
      .sample_i ($signed(samp_d[SDLY-1][k*DATA_W +: DATA_W])),
      .cos_i    (cos_w),
      .nsin_i   (nsin_w),
      .i_o      (i_o[k*OUT_W +: OUT_W]),
      .q_o      (q_o[k*OUT_W +: OUT_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= &lane_vld;
  end

  p_idle_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (i_o == '0 && q_o == '0));
  p_lanes_agree_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lane_vld == '0 || lane_vld == '1);
endmodule

// File: tb/par_nco_mixer_tb.sv
`timescale 1ns/1ps
module par_nco_mixer_tb;
  localparam int  LANES = 4;
  localparam int  DW    = 14;
  localparam int  OW    = 16;
  localparam int  LAT   = 16;
  localparam int  TOL   = 2;
  localparam real PI    = 3.14159265358979;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              valid = 1'b0;
  logic [31:0]       tune = '0;
  logic [LANES*DW-1:0] samples = '0;
  logic              valid_o;
  logic [LANES*OW-1:0] i_o, q_o;

  par_nco_mixer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .tune_i(tune),
    .samples_i(samples), .valid_o(valid_o), .i_o(i_o), .q_o(q_o)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;
  bit mon_en = 1'b0;
  logic [31:0] bacc = '0;
  logic [31:0] seed = 32'h1234_5678;

  int    cyc_q[$];
  string tag_q[$];
  int    ei_q[$];
  int    eq_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int rnd(input real v);
    if (v >= 0.0) return $rtoi($floor(v + 0.5));
    return -$rtoi($floor(-v + 0.5));
  endfunction

  function automatic logic signed [DW-1:0] next_sample();
    seed = seed * 32'd1103515245 + 32'd12345;
    return $signed(seed[29:16]);
  endfunction

  // Driver: one beat, expected values pushed to the scoreboard.
  task automatic beat(input logic [31:0] tw, input int s0, input int s1,
                      input int s2, input int s3, input string tag);
    int s[LANES];
    s[0] = s0; s[1] = s1; s[2] = s2; s[3] = s3;
    @(negedge clk);
    valid = 1'b1;
    tune  = tw;
    for (int k = 0; k < LANES; k++) begin
      logic [31:0] ph;
      real th;
      samples[k*DW +: DW] = DW'(s[k]);
      ph = bacc + 32'(k) * tw;
      th = 2.0 * PI * real'(ph[31:16]) / 65536.0;
      ei_q.push_back(rnd(real'(s[k]) * $cos(th)));
      eq_q.push_back(rnd(-real'(s[k]) * $sin(th)));
    end
    cyc_q.push_back(cyc + LAT);
    tag_q.push_back(tag);
    bacc = bacc + 32'd4 * tw;
  endtask

  task automatic rbeat(input logic [31:0] tw, input string tag);
    int a, b, c, d;
    a = int'(next_sample()); b = int'(next_sample());
    c = int'(next_sample()); d = int'(next_sample());
    beat(tw, a, b, c, d, tag);
  endtask

  task automatic idle(input int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      valid = 1'b0;
      tune  = 32'hDEAD_BEEF; // ignored while idle (R4)
      samples = '1;
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (mon_en && rst_n) begin
      if (valid_o) begin
        if (cyc_q.size() == 0) begin
          check(1'b0, "R2", "unexpected valid_o", 1, 0);
        end else begin
          int    ec;
          string tg;
          ec = cyc_q.pop_front();
          tg = tag_q.pop_front();
          check(cyc == ec, "R2", "output cycle", cyc, ec);
          for (int k = 0; k < LANES; k++) begin
            int ai, aq, xi, xq;
            ai = int'($signed(i_o[k*OW +: OW]));
            aq = int'($signed(q_o[k*OW +: OW]));
            xi = ei_q.pop_front();
            xq = eq_q.pop_front();
            check((ai - xi) <= TOL && (xi - ai) <= TOL,
                  {tg, "/R5"}, $sformatf("I lane %0d", k), ai, xi);
            check((aq - xq) <= TOL && (xq - aq) <= TOL,
                  {tg, "/R5"}, $sformatf("Q lane %0d", k), aq, xq);
          end
        end
      end else begin
        check(i_o == '0 && q_o == '0, "R1", "idle outputs nonzero", int'(i_o[15:0]), 0);
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(valid_o == 1'b0, "R1", "valid_o in reset", int'(valid_o), 0);
    check(i_o == '0 && q_o == '0, "R1", "data in reset", int'(i_o[15:0]), 0);
    rst_n = 1'b1;
    mon_en = 1'b1;
    idle(2);

    // R10 / R3: default one-third-cycle tuning, random samples
    for (int j = 0; j < 24; j++) rbeat(32'h5555_5555, "R10");
    // R3: constant sample shows lane phase steps directly
    for (int j = 0; j < 6; j++) beat(32'h5555_5555, 4000, 4000, 4000, 4000, "R3");

    // R4: gaps must not advance the phase
    rbeat(32'h0A3D_70A4, "R4");
    idle(3);
    rbeat(32'h0A3D_70A4, "R4");
    idle(1);
    beat(32'h0A3D_70A4, 5000, -5000, 3000, -3000, "R4");
    idle(7);
    rbeat(32'h0A3D_70A4, "R4");

    // R6: quarter-turn lanes and odd word across quadrants
    for (int j = 0; j < 8; j++) beat(32'h4000_0000, 6000, 6000, -6000, 6000, "R6");
    for (int j = 0; j < 20; j++) rbeat(32'h1234_5678, "R6");

    // R7: tuning changes every beat
    for (int j = 0; j < 6; j++) begin
      rbeat(32'h5555_5555, "R7");
      rbeat(32'hF000_0000, "R7");
      rbeat(32'h0357_9BDF, "R7");
    end

    // R8: zero tuning, all lanes held at one phase
    for (int j = 0; j < 6; j++) beat(32'h0, 7000, 7000, 7000, 7000, "R8");
    idle(2);
    for (int j = 0; j < 4; j++) beat(32'h0, -2500, 1200, 8191, -8192, "R8");

    // R9: full-scale samples
    for (int j = 0; j < 6; j++) beat(32'h4000_0000, -8192, 8191, -8192, 8191, "R9");
    for (int j = 0; j < 6; j++) beat(32'h5555_5555, 8191, -8192, 8191, -8192, "R9");
    for (int j = 0; j < 6; j++) beat(32'h2000_0000, -8192, -8192, 8191, 8191, "R9");

    idle(LAT + 6);
    check(cyc_q.size() == 0, "R2", "beats missing at output", cyc_q.size(), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule